// File: doc/BRIEF.md
# Configurable Macrocell Register Cell

This block is one programmable storage slice of a sum-of-products logic device. One storage element sits behind a static configuration word. That word makes it behave as a D, T, JK or SR flip-flop, or bypasses it so that the output is purely combinational. The same word picks the clock source and its active edge, and sets the value the cell takes at power-on. The data inputs, the clock enable, the array clock and the asynchronous preset and clear all come from upstream product-term logic. A shared active-low global clear and a power-on reset input come from outside the logic array.

The configuration inputs are meant to be set once and then held. Software does not change them during operation. When a clock-selection field does change, the selected clock can show an edge. Any caller that reprograms the cell must hold the data inputs at a value that leaves the stored bit unchanged while it does so.

Top module: `mc_regcell`

## Requirements
- R1: With `cfg_kind`=0 (D), the stored bit takes `din_a` on each active clock edge.
- R2: With `cfg_kind`=1 (T), an active edge inverts the stored bit when `din_a` is 1 and keeps it when `din_a` is 0.
- R3: With `cfg_kind`=2 (JK), `din_a` is J and `din_b` is K. The pair {J,K} gives 00 hold, 01 clear, 10 set and 11 invert on each active edge.
- R4: With `cfg_kind`=3 (SR), `din_a` is S and `din_b` is R. The pair {S,R} gives 10 set and 01 clear, and both 00 and 11 hold.
- R5: When `cfg_bypass` is 1, `q_o` equals `din_a` combinationally. When it is 0, `q_o` shows the stored bit.
- R6: `cfg_clk_mode`=0 clocks the cell from the selected global clock. Values 2 and 3 clock it on the rising edge of `arr_clk`, and the global clocks then have no effect.
- R7: `cfg_clk_mode`=1 clocks from the selected global clock, but only when `clk_en` is 1. When `clk_en` is 0, the stored bit holds for every flip-flop kind.
- R8: `cfg_gsel`=0 selects `gclk_a` and 1 selects `gclk_b`. The unselected clock has no effect. With `cfg_ginv`=1, the falling edge of the selected clock is the active one.
- R9: `clr_i` high or `gclr_n` low forces the stored bit to 0 at once, without a clock. Either one overrides `pre_i` and any clock edge.
- R10: When no clear is active, `pre_i` high forces the stored bit to 1 at once, and the bit stays 1 after `pre_i` falls.
- R11: `por_i` high loads `cfg_init` asynchronously and overrides every clear, preset and clock. `cfg_init`=0 gives a low power-up value, which is the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk_a | input | 1 | Global clock A |
| gclk_b | input | 1 | Global clock B |
| arr_clk | input | 1 | Clock from the logic array (modes 2 and 3) |
| clk_en | input | 1 | Active-high clock enable for mode 1 |
| por_i | input | 1 | Power-on reset, active high, loads `cfg_init` |
| gclr_n | input | 1 | Global clear, active low |
| pre_i | input | 1 | Asynchronous preset from logic, active high |
| clr_i | input | 1 | Asynchronous clear from logic, active high |
| cfg_kind | input | 2 | Flip-flop kind: 0 D, 1 T, 2 JK, 3 SR |
| cfg_bypass | input | 1 | 1 routes `din_a` straight to `q_o` |
| cfg_clk_mode | input | 2 | Clock source mode: 0 global, 1 global with enable, 2/3 array |
| cfg_gsel | input | 1 | Global clock select: 0 A, 1 B |
| cfg_ginv | input | 1 | 1 makes the falling global edge the active one |
| cfg_init | input | 1 | Power-up value |
| din_a | input | 1 | D, T, J or S input, and the bypass input |
| din_b | input | 1 | K or R input |
| q_o | output | 1 | Cell output, registered or combinational |

## Verification
On every rising edge of `gclk_a`, the assertions check that any active clear holds the output low. They also check that a preset without a clear holds it high, that the D and T kinds follow their next-state rules under the plain global clock, and that a low enable in mode 1 freezes the stored bit. The bench scenarios are the only place that several behaviours show up. These are the full JK and SR encoding tables, and bypass switching. They also include array clocking with the global clock ignored, and the unselected global clock having no effect. The last ones are falling-edge capture with inversion, and power-on reset overriding a clear, with both power-up values.

// File: rtl/mc_regcell.sv
module mc_regcell (
  input  logic       gclk_a,
  input  logic       gclk_b,
  input  logic       arr_clk,
  input  logic       clk_en,
  input  logic       por_i,
  input  logic       gclr_n,
  input  logic       pre_i,
  input  logic       clr_i,
  input  logic [1:0] cfg_kind,
  input  logic       cfg_bypass,
  input  logic [1:0] cfg_clk_mode,
  input  logic       cfg_gsel,
  input  logic       cfg_ginv,
  input  logic       cfg_init,
  input  logic       din_a,
  input  logic       din_b,
  output logic       q_o
);

  typedef enum logic [1:0] {K_D = 2'd0, K_T = 2'd1, K_JK = 2'd2, K_SR = 2'd3} kind_e;

  logic glb_clk, clk_sel, clr_any, cap_en;
  logic q_r, q_nxt;

  assign glb_clk = (cfg_gsel ? gclk_b : gclk_a) ^ cfg_ginv;
  assign clk_sel = cfg_clk_mode[1] ? arr_clk : glb_clk;
  assign clr_any = clr_i | ~gclr_n;
  assign cap_en  = (cfg_clk_mode == 2'd1) ? clk_en : 1'b1;

  always_comb begin
    q_nxt = q_r;
    if (cap_en) begin
      unique case (kind_e'(cfg_kind))
        K_D:  q_nxt = din_a;
        K_T:  q_nxt = q_r ^ din_a;
        K_JK: case ({din_a, din_b})
                2'b01:   q_nxt = 1'b0;
                2'b10:   q_nxt = 1'b1;
                2'b11:   q_nxt = ~q_r;
                default: q_nxt = q_r;
              endcase
        K_SR: case ({din_a, din_b})
                2'b01:   q_nxt = 1'b0;
                2'b10:   q_nxt = 1'b1;
                default: q_nxt = q_r;
              endcase
        default: q_nxt = q_r;
      endcase
    end
  end

  always_ff @(posedge clk_sel or posedge por_i or posedge clr_any or posedge pre_i) begin
    if (por_i)        q_r <= cfg_init;
    else if (clr_any) q_r <= 1'b0;
    else if (pre_i)   q_r <= 1'b1;
    else              q_r <= q_nxt;
  end

  assign q_o = cfg_bypass ? din_a : q_r;

endmodule

// File: rtl/mc_regcell_chk.sv
module mc_regcell_chk (
  input logic       gclk_a,
  input logic       por_i,
  input logic       gclr_n,
  input logic       pre_i,
  input logic       clr_i,
  input logic [1:0] cfg_kind,
  input logic       cfg_bypass,
  input logic [1:0] cfg_clk_mode,
  input logic       cfg_gsel,
  input logic       cfg_ginv,
  input logic       clk_en,
  input logic       din_a,
  input logic       q_o
);

  logic quiet, d_cfg, t_cfg, m1_cfg;
  assign quiet  = !pre_i && !clr_i && gclr_n && !cfg_bypass && !cfg_gsel && !cfg_ginv;
  assign d_cfg  = quiet && cfg_clk_mode == 2'd0 && cfg_kind == 2'd0;
  assign t_cfg  = quiet && cfg_clk_mode == 2'd0 && cfg_kind == 2'd1;
  assign m1_cfg = quiet && cfg_clk_mode == 2'd1;

  a_r9_clear_forces_low: assert property (@(posedge gclk_a) disable iff (por_i)
    (clr_i || !gclr_n) && !cfg_bypass |-> !q_o);

  a_r10_preset_forces_high: assert property (@(posedge gclk_a) disable iff (por_i)
    pre_i && !clr_i && gclr_n && !cfg_bypass |-> q_o);

  a_r1_d_capture: assert property (@(posedge gclk_a) disable iff (por_i)
    d_cfg && $past(d_cfg) |-> q_o == $past(din_a));

  a_r2_t_toggle: assert property (@(posedge gclk_a) disable iff (por_i)
    t_cfg && $past(t_cfg) && $past(din_a) |-> q_o != $past(q_o));

  a_r7_enable_low_holds: assert property (@(posedge gclk_a) disable iff (por_i)
    m1_cfg && $past(m1_cfg) && !$past(clk_en) |-> q_o == $past(q_o));

endmodule

bind mc_regcell mc_regcell_chk chk_i (
  .gclk_a(gclk_a), .por_i(por_i), .gclr_n(gclr_n), .pre_i(pre_i), .clr_i(clr_i),
  .cfg_kind(cfg_kind), .cfg_bypass(cfg_bypass), .cfg_clk_mode(cfg_clk_mode),
  .cfg_gsel(cfg_gsel), .cfg_ginv(cfg_ginv), .clk_en(clk_en), .din_a(din_a), .q_o(q_o)
);

// File: tb/mc_regcell_tb_top.sv
`timescale 1ns/100ps
module mc_regcell_tb_top;

  logic gclk_a = 1'b0, gclk_b = 1'b0, arr_clk = 1'b0, clk_en = 1'b0;
  logic por_i = 1'b1, gclr_n = 1'b1, pre_i = 1'b0, clr_i = 1'b0;
  logic [1:0] cfg_kind = 2'd0, cfg_clk_mode = 2'd0;
  logic cfg_bypass = 1'b0, cfg_gsel = 1'b0, cfg_ginv = 1'b0, cfg_init = 1'b0;
  logic din_a = 1'b0, din_b = 1'b0;
  logic q_o;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic v; int rid; } exp_t;
  exp_t sb[$];

  always #4 gclk_a = ~gclk_a;

  mc_regcell dut_i (
    .gclk_a(gclk_a), .gclk_b(gclk_b), .arr_clk(arr_clk), .clk_en(clk_en),
    .por_i(por_i), .gclr_n(gclr_n), .pre_i(pre_i), .clr_i(clr_i),
    .cfg_kind(cfg_kind), .cfg_bypass(cfg_bypass), .cfg_clk_mode(cfg_clk_mode),
    .cfg_gsel(cfg_gsel), .cfg_ginv(cfg_ginv), .cfg_init(cfg_init),
    .din_a(din_a), .din_b(din_b), .q_o(q_o)
  );

  task automatic tick();
    @(posedge gclk_a);
    #2;
  endtask

  task automatic expect_q(input logic v, input int rid);
    exp_t e;
    #1;
    e.v = v;
    e.rid = rid;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  task automatic pulse(ref logic c);
    c = 1'b1;
    #1;
    c = 1'b0;
  endtask

  initial begin
    #0.5;
    forever begin
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (q_o !== e.v) begin
          n_fail++;
          $display("FAIL R%0d: q_o=%b expected %b at %0t", e.rid, q_o, e.v, $time);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #160000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
    end
  end

  initial begin
    // R11: reset state with low power-up value
    repeat (3) tick();
    expect_q(1'b0, 11);
    por_i = 1'b0;

    // R1: D capture
    din_a = 1'b1; tick(); expect_q(1'b1, 1);
    din_a = 1'b0; tick(); expect_q(1'b0, 1);
    din_a = 1'b1; tick(); expect_q(1'b1, 1);

    // R2: T toggle and hold
    cfg_kind = 2'd1;
    tick(); expect_q(1'b0, 2);
    tick(); expect_q(1'b1, 2);
    din_a = 1'b0; tick(); expect_q(1'b1, 2);

    // R3: JK table
    cfg_kind = 2'd2;
    din_a = 1'b0; din_b = 1'b1; tick(); expect_q(1'b0, 3);
    din_a = 1'b1; din_b = 1'b0; tick(); expect_q(1'b1, 3);
    din_a = 1'b0; din_b = 1'b0; tick(); expect_q(1'b1, 3);
    din_a = 1'b1; din_b = 1'b1; tick(); expect_q(1'b0, 3);
    tick(); expect_q(1'b1, 3);

    // R4: SR table, 11 holds
    cfg_kind = 2'd3;
    din_a = 1'b0; din_b = 1'b1; tick(); expect_q(1'b0, 4);
    din_a = 1'b0; din_b = 1'b0; tick(); expect_q(1'b0, 4);
    din_a = 1'b1; din_b = 1'b0; tick(); expect_q(1'b1, 4);
    din_a = 1'b1; din_b = 1'b1; tick(); expect_q(1'b1, 4);
    din_a = 1'b0; din_b = 1'b1; tick(); expect_q(1'b0, 4);
    din_a = 1'b1; din_b = 1'b1; tick(); expect_q(1'b0, 4);

    // R5: bypass, stored bit 0 meanwhile
    cfg_kind = 2'd0; din_a = 1'b0; din_b = 1'b0;
    tick();
    cfg_bypass = 1'b1; din_a = 1'b1; expect_q(1'b1, 5);
    din_a = 1'b0; expect_q(1'b0, 5);
    din_a = 1'b1; cfg_bypass = 1'b0; expect_q(1'b0, 5);
    din_a = 1'b0;

    // R7: mode 1 enable gating
    cfg_clk_mode = 2'd1; clk_en = 1'b0; din_a = 1'b1;
    tick(); expect_q(1'b0, 7);
    clk_en = 1'b1; tick(); expect_q(1'b1, 7);
    cfg_kind = 2'd1; clk_en = 1'b0; tick(); expect_q(1'b1, 7);
    clk_en = 1'b1; tick(); expect_q(1'b0, 7);
    din_a = 1'b0; clk_en = 1'b0; cfg_clk_mode = 2'd0; cfg_kind = 2'd0;

    // R6: array clock, global clock ignored
    cfg_clk_mode = 2'd2; din_a = 1'b1;
    tick(); expect_q(1'b0, 6);
    pulse(arr_clk); expect_q(1'b1, 6);
    cfg_clk_mode = 2'd0;

    // R8: clock B selected, A ignored
    cfg_gsel = 1'b1; din_a = 1'b0;
    tick(); expect_q(1'b1, 8);
    pulse(gclk_b); expect_q(1'b0, 8);
    cfg_gsel = 1'b0; cfg_ginv = 1'b1;

    // R8: inverted clock captures on falling edge only
    @(posedge gclk_a); #1; din_a = 1'b1;
    expect_q(1'b0, 8);
    @(negedge gclk_a); #1;
    expect_q(1'b1, 8);
    cfg_ginv = 1'b0;

    // R9 / R10: asynchronous controls under the array clock
    cfg_clk_mode = 2'd2;
    clr_i = 1'b1; expect_q(1'b0, 9);
    pre_i = 1'b1; expect_q(1'b0, 9);
    pulse(arr_clk); expect_q(1'b0, 9);
    pre_i = 1'b0; clr_i = 1'b0; expect_q(1'b0, 9);
    pre_i = 1'b1; expect_q(1'b1, 10);
    pre_i = 1'b0; expect_q(1'b1, 10);
    gclr_n = 1'b0; expect_q(1'b0, 9);
    pre_i = 1'b1; expect_q(1'b0, 9);
    pre_i = 1'b0; gclr_n = 1'b1; expect_q(1'b0, 9);

    // R11: power-up high, overrides clear, then low default
    cfg_init = 1'b1; por_i = 1'b1; expect_q(1'b1, 11);
    clr_i = 1'b1; expect_q(1'b1, 11);
    clr_i = 1'b0; por_i = 1'b0; expect_q(1'b1, 11);
    cfg_init = 1'b0; por_i = 1'b1; expect_q(1'b0, 11);
    por_i = 1'b0; expect_q(1'b0, 11);

    finish_run();
  end

endmodule